// File: doc/BRIEF.md
# Square-Wave Tone Channel with Attenuation

This block is one tone voice of a programmable sound generator. It holds no bus logic of its own: a separate register interface supplies a 10-bit period value and a 4-bit attenuation code, and a shared prescaler supplies a one-cycle tick. The channel counts ticks down from the period value. Each time the count runs out, it reloads and inverts its square bit, so every half-period lasts exactly n ticks. With the prescaler dividing the master clock by 16, the output frequency is the master clock divided by 32·n. For example, n = 0x11C gives about 440 Hz from a 4 MHz clock.

The channel drives an unsigned amplitude for the downstream mixer. The attenuation code is inverted, so code 0 is the loudest level and code 15 is silent. While the square bit is low the amplitude is zero, so the waveform carries no negative swing. A one-cycle toggle strobe marks every edge of the square bit, and a noise source can use it as its shift clock.

Top module: `sqtone_chan`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `sqOut` = 0, `ampOut` = 0 and `toggleStb` = 0.
- R2: The down-counter is zero after reset, so the first tick after reset inverts `sqOut`.
- R3: For a period value n ≥ 1, consecutive inversions of `sqOut` are exactly n ticks apart. Each inversion happens at the clock edge that samples the tick.
- R4: A period value of 0 behaves as 1, and `sqOut` inverts on every tick.
- R5: In a cycle where `tick` is low, `sqOut` does not change at the next edge.
- R6: `toggleStb` is high for exactly the one cycle in which `sqOut` has just changed, and is low at all other times.
- R7: The amplitude is 15 minus `atten` while `sqOut` is 1, and 0 while `sqOut` is 0.
- R8: An `atten` value of 15 holds `ampOut` at 0 for both levels of the square bit.
- R9: A new period value written mid-count does not shorten or lengthen the half-period in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled clock-enable pulse, one cycle wide |
| period | input | 10 | Half-period in ticks; 0 acts as 1 |
| atten | input | 4 | Attenuation code; 0 is loudest, 15 is silent |
| sqOut | output | 1 | Raw square-wave bit |
| ampOut | output | 4 | Unsigned scaled amplitude |
| toggleStb | output | 1 | One-cycle pulse on each square-bit inversion |

## Verification
A wrong counter value shows at the ports as a toggle strobe on the wrong tick. The monitor compares every strobe against the tick index the scoreboard predicted, so the error is caught at the first misplaced edge, or at the first tick past a missed one. A stuck or wrongly toggled square bit shows the same cycle as a wrong `sqOut` level and a wrong amplitude, because both are compared on every cycle. Changing the period value right after a reload shows whether the reload value is taken at the right moment: the expected edge moves by the difference between the old and new periods.

// File: rtl/sqtone_pkg.sv
package sqtone_pkg;
  // Strobes from the counter control to the output datapath
  typedef struct packed {
    logic flip;
  } ctlStrobes_t;
endpackage

// File: rtl/sqtone_ctrl.sv
module sqtone_ctrl
  import sqtone_pkg::*;
#(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output ctlStrobes_t         ctl
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] effPeriod;
  logic                expired;

  // A zero period is promoted to one so the channel keeps running
  assign effPeriod = (period == '0) ? PERIOD_W'(1) : period;
  // Count of 0 (after reset) or 1 (last tick of a half-period) ends the phase
  assign expired   = (cnt[PERIOD_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (expired) cnt <= effPeriod;
      else         cnt <= cnt - PERIOD_W'(1);
    end
  end

  always_comb begin
    ctl.flip = tick && expired;
  end
endmodule

// File: rtl/sqtone_dpath.sv
module sqtone_dpath
  import sqtone_pkg::*;
#(
  parameter int ATT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      ctl,
  input  logic [ATT_W-1:0] atten,
  output logic             sqOut,
  output logic [ATT_W-1:0] ampOut,
  output logic             toggleStb
);
  localparam logic [ATT_W-1:0] ATT_MUTE = '1;

  logic             sqReg;
  logic             stbReg;
  logic [ATT_W-1:0] level;

  always_ff @(posedge clk) begin
    if (rst) begin
      sqReg  <= 1'b0;
      stbReg <= 1'b0;
    end else begin
      sqReg  <= sqReg ^ ctl.flip;
      stbReg <= ctl.flip;
    end
  end

  // Inverted attenuation: code 0 gives the full-scale level
  assign level = ATT_MUTE - atten;

  always_comb begin
    if (!sqReg || atten == ATT_MUTE) ampOut = '0;
    else                             ampOut = level;
  end

  assign sqOut     = sqReg;
  assign toggleStb = stbReg;
endmodule

// File: rtl/sqtone_chan.sv
module sqtone_chan
  import sqtone_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int ATT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  input  logic [ATT_W-1:0]    atten,
  output logic                sqOut,
  output logic [ATT_W-1:0]    ampOut,
  output logic                toggleStb
);
  ctlStrobes_t ctl;

  sqtone_ctrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .period (period),
    .ctl    (ctl)
  );

  sqtone_dpath #(.ATT_W(ATT_W)) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .atten     (atten),
    .sqOut     (sqOut),
    .ampOut    (ampOut),
    .toggleStb (toggleStb)
  );
endmodule

// File: rtl/sqtone_chk.sv
module sqtone_chk #(
  parameter int PERIOD_W = 10,
  parameter int ATT_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic [PERIOD_W-1:0] period,
  input logic [ATT_W-1:0]    atten,
  input logic                sqOut,
  input logic [ATT_W-1:0]    ampOut,
  input logic                toggleStb
);
  logic [PERIOD_W-1:0] unusedPeriod;
  assign unusedPeriod = period;

  // R6: strobe marks exactly the cycles where the square bit just changed
  p_stb_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    toggleStb == (sqOut != $past(sqOut)));

  // R5: no tick, no edge
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sqOut));

  // R3: every strobe follows a sampled tick
  p_stb_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    toggleStb |-> $past(tick));

  // R7: low half of the wave is silent
  p_low_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !sqOut |-> ampOut == '0);

  // R8: full attenuation mutes the channel
  p_mute_r8: assert property (@(posedge clk) disable iff (rst)
    (atten == '1) |-> ampOut == '0);
endmodule

bind sqtone_chan sqtone_chk #(.PERIOD_W(PERIOD_W), .ATT_W(ATT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .period    (period),
  .atten     (atten),
  .sqOut     (sqOut),
  .ampOut    (ampOut),
  .toggleStb (toggleStb)
);

// File: tb/sqtone_chan_tb_top.sv
`timescale 1ns/1ps
module sqtone_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [9:0] period = '0;
  logic [3:0] atten = '0;
  logic       sqOut;
  logic [3:0] ampOut;
  logic       toggleStb;

  int checks = 0;
  int errors = 0;
  int tickNum = 0;
  int popped = 0;
  bit monOn = 1'b0;
  int qExp[$];

  always #4 clk = ~clk;

  sqtone_chan dut_i (
    .clk(clk), .rst(rst), .tick(tick), .period(period), .atten(atten),
    .sqOut(sqOut), .ampOut(ampOut), .toggleStb(toggleStb)
  );

  always @(posedge clk) begin
    if (rst) tickNum <= 0;
    else if (tick) tickNum <= tickNum + 1;
  end

  // Monitor: pops expected toggle ticks and compares outputs every cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (monOn && !rst) begin
        if (toggleStb) begin
          checks++;
          if (qExp.size() == 0) begin
            errors++;
            $display("FAIL R6 unexpected strobe at tick %0d expected none", tickNum);
          end else begin
            int e;
            e = qExp.pop_front();
            popped++;
            if (tickNum != e) begin
              errors++;
              $display("FAIL %s toggle at tick %0d expected %0d",
                       (e == 1) ? "R2" : "R3", tickNum, e);
            end
          end
        end else if (qExp.size() > 0 && qExp[0] < tickNum) begin
          int e;
          checks++;
          errors++;
          e = qExp.pop_front();
          popped++;
          $display("FAIL R3 missed toggle actual tick %0d expected %0d", tickNum, e);
        end
        begin
          logic expSq;
          logic [3:0] expAmp;
          expSq  = popped[0];
          expAmp = expSq ? (4'd15 - atten) : 4'd0;
          checks++;
          if (sqOut !== expSq) begin
            errors++;
            $display("FAIL R5 sqOut %0b expected %0b", sqOut, expSq);
          end
          checks++;
          if (ampOut !== expAmp) begin
            errors++;
            $display("FAIL %s ampOut %0d expected %0d",
                     (atten == 4'd15) ? "R8" : "R7", ampOut, expAmp);
          end
        end
      end
    end
  end

  task automatic oneTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic int effOf(int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Driver: resets, pushes the expected toggle ticks, then issues ticks
  task automatic runCase(int n1, int n2, int att, int cnt);
    int t;
    monOn = 1'b0;
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    period = 10'(n1); atten = 4'(att);
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (sqOut !== 1'b0 || ampOut !== 4'd0 || toggleStb !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset sq=%0b amp=%0d stb=%0b expected 0 0 0", sqOut, ampOut, toggleStb);
    end
    qExp.delete();
    popped = 0;
    @(negedge clk);
    rst = 1'b0;
    monOn = 1'b1;
    t = 1;
    qExp.push_back(t);
    for (int i = 1; i < cnt; i++) begin
      t += (i == 1) ? effOf(n1) : effOf(n2);
      qExp.push_back(t);
    end
    for (int k = 1; k <= t; k++) begin
      oneTick();
      if (k == 1) period = 10'(n2);  // R9: change after the first reload
    end
    repeat (3) @(negedge clk);
    checks++;
    if (qExp.size() != 0) begin
      errors++;
      $display("FAIL R3 pending toggles %0d expected 0", qExp.size());
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    runCase(5, 5, 0, 4);       // R2 R3 R7 full volume
    runCase(0, 0, 8, 5);       // R4 zero period
    runCase(1, 1, 15, 4);      // R8 muted
    runCase(3, 7, 5, 4);       // R9 period change mid-count
    runCase(7, 2, 3, 4);       // R9 shorter new period
    runCase(1023, 1023, 2, 2); // R3 widest period
    monOn = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule